// File: doc/BRIEF.md
# Interrupt Controller Command Word Interface

This block is the byte-wide register front end of an eight-input priority interrupt controller. Host software reaches it through a one-bit address, write and read strobes and an 8-bit data bus. A short initialization sequence programs the vector base, the cascade arrangement and the operating modes. After that sequence, writes are taken as run-time commands: load the mask, signal end of interrupt, or pick which status register appears on reads.

The priority resolver is a separate block. This interface gives it the stored configuration and the mask. It also gives it single-cycle pulses for end of interrupt, poll request and in-service clear. In return, the resolver supplies its request and in-service vectors, which this block places on the read bus.

Some initialization words are optional. The first word decides whether the cascade word and the mode word are expected. A write's meaning therefore depends on the address, on the data bits and on how far the sequence has progressed.

Top module: `pic_cmd_if`

## Requirements
- R1: After synchronous reset the sequencer is idle (`init_busy`=0), and mask, vector base, cascade, mode bits and all pulses are 0. Address-0 reads return the request vector.
- R2: A write at address 0 with data bit 4 set starts initialization from any state. On the next edge: `init_busy`=1, mask=0, cascade and the four mode bits cleared, reads select the request vector, and `isr_clr` pulses for one cycle. Its bit 0 set means a mode word is expected, bit 1 set means single (non-cascaded) operation, and bit 3 is latched as `level_trig`.
- R3: The first address-1 write after R2 sets `vec_base` to data bits 7:3.
- R4: In cascaded operation the next address-1 write is stored whole as `casc_cfg`. In single operation this step is skipped and `casc_cfg` stays 0.
- R5: When requested, the next address-1 write is the mode word: bit 0 → `vec_mode`, bit 1 → `auto_eoi`, bit 3 → `buffered`, bit 4 → `special_nest`. When not requested, that write already loads the mask.
- R6: With `init_busy`=0, an address-1 write loads the mask. An address-1 read returns the mask. The mask is not changed by address-1 writes during initialization.
- R7: With `init_busy`=0, an address-0 write with bits 4:3 = 01 is a read-select command. Bits 1:0 = 10 make address-0 reads return the request vector, 11 the in-service vector, and 0x leaves the choice unchanged.
- R8: A read-select command with bit 2 set raises `poll_pulse` for exactly the cycle after the write.
- R9: With `init_busy`=0, an address-0 write with bits 4:3 = 00 raises `eoi_pulse` for the cycle after the write, with `eoi_cmd` = data bits 7:5.
- R10: While `init_busy`=1, address-0 writes without bit 4 have no effect: no pulse, and no change of sequence state. `rdata` is 0 whenever `rd_en` is low.
- R11: `init_busy` falls on the edge of the last expected word: the vector word in single mode without a mode word, otherwise the cascade or mode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 1 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, 0 when not reading |
| irr_in | input | 8 | Request vector from the priority core |
| isr_in | input | 8 | In-service vector from the priority core |
| imr | output | 8 | Interrupt mask |
| vec_base | output | 5 | Upper vector bits |
| casc_cfg | output | 8 | Slave bitmap (master) or identity (slave) |
| single_mode | output | 1 | No cascade |
| level_trig | output | 1 | Level-sensitive inputs |
| vec_mode | output | 1 | 16-bit processor vector format |
| auto_eoi | output | 1 | Automatic end of interrupt |
| buffered | output | 1 | Buffered bus mode |
| special_nest | output | 1 | Special fully nested mode |
| eoi_pulse | output | 1 | End-of-interrupt command strobe |
| eoi_cmd | output | 3 | End-of-interrupt command bits |
| poll_pulse | output | 1 | Poll request strobe |
| isr_clr | output | 1 | Clear in-service state strobe |
| init_busy | output | 1 | Initialization sequence in progress |

## Verification
Every stored value and every pulse is registered. Each one appears on the first clock edge after the write that causes it, and the pulses drop one edge later. The bench drives a write on a falling edge and checks the effect on the next falling edge. It checks that a pulse has ended one falling edge after that. Read data is combinational, so it is checked shortly after the address and `rd_en` are set, with no clock edge in between.

// File: rtl/piccmd_pkg.sv
package piccmd_pkg;

    localparam int DW     = 8;
    localparam int VW     = 5;
    localparam int CMDW   = 3;
    localparam int VLSB   = DW - VW;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_VEC,
        SEQ_CASC,
        SEQ_MODE
    } seq_t;

    typedef enum logic [1:0] {
        K_INIT,
        K_EOI,
        K_RSEL,
        K_DATA
    } kind_t;

    typedef struct packed {
        logic [VW-1:0] vbase;
        logic [DW-1:0] casc;
        logic          single;
        logic          level;
        logic          vmode;
        logic          aeoi;
        logic          bufm;
        logic          sfnm;
    } cfg_t;

    function automatic kind_t classify(input logic a, input logic [DW-1:0] d);
        if (a)    return K_DATA;
        if (d[4]) return K_INIT;
        if (d[3]) return K_RSEL;
        return K_EOI;
    endfunction

    function automatic seq_t after_vec(input logic single, input logic need_mode);
        if (!single)   return SEQ_CASC;
        if (need_mode) return SEQ_MODE;
        return SEQ_IDLE;
    endfunction

endpackage

// File: rtl/icw_seq.sv
module icw_seq
    import piccmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  kind_t         kind,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg,
    output logic          busy,
    output logic          clr_pulse
);
    seq_t st;
    logic need_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SEQ_IDLE;
            cfg       <= '0;
            need_mode <= 1'b0;
            clr_pulse <= 1'b0;
        end else begin
            clr_pulse <= 1'b0;
            if (wr_en && kind == K_INIT) begin
                cfg.casc   <= '0;
                cfg.vmode  <= 1'b0;
                cfg.aeoi   <= 1'b0;
                cfg.bufm   <= 1'b0;
                cfg.sfnm   <= 1'b0;
                cfg.single <= wdata[1];
                cfg.level  <= wdata[3];
                need_mode  <= wdata[0];
                clr_pulse  <= 1'b1;
                st         <= SEQ_VEC;
            end else if (wr_en && kind == K_DATA) begin
                case (st)
                    SEQ_VEC: begin
                        cfg.vbase <= wdata[DW-1:VLSB];
                        st        <= after_vec(cfg.single, need_mode);
                    end
                    SEQ_CASC: begin
                        cfg.casc <= wdata;
                        st       <= need_mode ? SEQ_MODE : SEQ_IDLE;
                    end
                    SEQ_MODE: begin
                        cfg.vmode <= wdata[0];
                        cfg.aeoi  <= wdata[1];
                        cfg.bufm  <= wdata[3];
                        cfg.sfnm  <= wdata[4];
                        st        <= SEQ_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy = (st != SEQ_IDLE);

endmodule

// File: rtl/ocw_dec.sv
module ocw_dec
    import piccmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  kind_t           kind,
    input  logic [DW-1:0]   wdata,
    input  logic            busy,
    output logic [DW-1:0]   mask,
    output logic            sel_isr,
    output logic            eoi_p,
    output logic [CMDW-1:0] eoi_bits,
    output logic            poll_p
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask     <= '0;
            sel_isr  <= 1'b0;
            eoi_p    <= 1'b0;
            eoi_bits <= '0;
            poll_p   <= 1'b0;
        end else begin
            eoi_p  <= 1'b0;
            poll_p <= 1'b0;
            if (wr_en) begin
                case (kind)
                    K_INIT: begin
                        mask    <= '0;
                        sel_isr <= 1'b0;
                    end
                    K_DATA: if (!busy) mask <= wdata;
                    K_RSEL: if (!busy) begin
                        if (wdata[1]) sel_isr <= wdata[0];
                        poll_p <= wdata[2];
                    end
                    K_EOI: if (!busy) begin
                        eoi_p    <= 1'b1;
                        eoi_bits <= wdata[DW-1:DW-CMDW];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/rd_mux.sv
module rd_mux
    import piccmd_pkg::*;
(
    input  logic          rd_en,
    input  logic          addr,
    input  logic          sel_isr,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] irr,
    input  logic [DW-1:0] isr,
    output logic [DW-1:0] dout
);
    always_comb begin
        dout = '0;
        if (rd_en) begin
            if (addr)         dout = mask;
            else if (sel_isr) dout = isr;
            else              dout = irr;
        end
    end

endmodule

// File: rtl/pic_cmd_if.sv
module pic_cmd_if
    import piccmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            addr,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [DW-1:0]   irr_in,
    input  logic [DW-1:0]   isr_in,
    output logic [DW-1:0]   imr,
    output logic [VW-1:0]   vec_base,
    output logic [DW-1:0]   casc_cfg,
    output logic            single_mode,
    output logic            level_trig,
    output logic            vec_mode,
    output logic            auto_eoi,
    output logic            buffered,
    output logic            special_nest,
    output logic            eoi_pulse,
    output logic [CMDW-1:0] eoi_cmd,
    output logic            poll_pulse,
    output logic            isr_clr,
    output logic            init_busy
);
    kind_t kind;
    cfg_t  cfg;
    logic  sel_isr;

    assign kind = classify(addr, wdata);

    icw_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .kind      (kind),
        .wdata     (wdata),
        .cfg       (cfg),
        .busy      (init_busy),
        .clr_pulse (isr_clr)
    );

    ocw_dec u_ocw (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .kind     (kind),
        .wdata    (wdata),
        .busy     (init_busy),
        .mask     (imr),
        .sel_isr  (sel_isr),
        .eoi_p    (eoi_pulse),
        .eoi_bits (eoi_cmd),
        .poll_p   (poll_pulse)
    );

    rd_mux u_rd (
        .rd_en   (rd_en),
        .addr    (addr),
        .sel_isr (sel_isr),
        .mask    (imr),
        .irr     (irr_in),
        .isr     (isr_in),
        .dout    (rdata)
    );

    assign vec_base     = cfg.vbase;
    assign casc_cfg     = cfg.casc;
    assign single_mode  = cfg.single;
    assign level_trig   = cfg.level;
    assign vec_mode     = cfg.vmode;
    assign auto_eoi     = cfg.aeoi;
    assign buffered     = cfg.bufm;
    assign special_nest = cfg.sfnm;

endmodule

// File: rtl/pic_cmd_if_chk.sv
module pic_cmd_if_chk
    import piccmd_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            addr,
    input logic            wr_en,
    input logic            rd_en,
    input logic [DW-1:0]   wdata,
    input logic [DW-1:0]   rdata,
    input logic [DW-1:0]   imr,
    input logic [VW-1:0]   vec_base,
    input logic            eoi_pulse,
    input logic            poll_pulse,
    input logic            isr_clr,
    input logic            init_busy
);
    p_init_clears_r2: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && !addr && wdata[4]) |-> (imr == '0 && init_busy && isr_clr));

    p_vec_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!init_busy && !$past(init_busy)) |-> $stable(vec_base));

    p_mask_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (init_busy && $past(init_busy)) |-> $stable(imr));

    p_poll_cause_r8: assert property (@(posedge clk) disable iff (rst)
        poll_pulse |-> $past(wr_en && !addr && wdata[4:3] == 2'b01 && wdata[2] && !init_busy));

    p_eoi_cause_r9: assert property (@(posedge clk) disable iff (rst)
        eoi_pulse |-> $past(wr_en && !addr && wdata[4:3] == 2'b00 && !init_busy));

    p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rdata == '0);

endmodule

bind pic_cmd_if pic_cmd_if_chk u_chk (.*);

// File: tb/pic_cmd_if_bench.sv
module pic_cmd_if_bench;
    import piccmd_pkg::*;

    typedef struct packed {
        logic       wa;
        logic [7:0] wd;
        logic       ra;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam logic [7:0] IRRV = 8'hA5;
    localparam logic [7:0] ISRV = 8'h3C;

    localparam vec_t TBL [0:14] = '{
        '{1'b0, 8'h11, 1'b1, 8'h00, 4'd2},
        '{1'b1, 8'h20, 1'b1, 8'h00, 4'd3},
        '{1'b1, 8'h04, 1'b1, 8'h00, 4'd4},
        '{1'b1, 8'h01, 1'b1, 8'h00, 4'd5},
        '{1'b1, 8'hFB, 1'b1, 8'hFB, 4'd6},
        '{1'b0, 8'h0B, 1'b0, ISRV,  4'd7},
        '{1'b0, 8'h09, 1'b0, ISRV,  4'd7},
        '{1'b0, 8'h0A, 1'b0, IRRV,  4'd7},
        '{1'b0, 8'h13, 1'b1, 8'h00, 4'd2},
        '{1'b1, 8'h48, 1'b1, 8'h00, 4'd3},
        '{1'b1, 8'h1F, 1'b1, 8'h00, 4'd4},
        '{1'b1, 8'h5A, 1'b1, 8'h5A, 4'd5},
        '{1'b0, 8'h1A, 1'b0, IRRV,  4'd2},
        '{1'b1, 8'h78, 1'b1, 8'h00, 4'd3},
        '{1'b1, 8'h33, 1'b1, 8'h33, 4'd5}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, imr, casc_cfg;
    logic [7:0] irr_in = IRRV, isr_in = ISRV;
    logic [4:0] vec_base;
    logic [2:0] eoi_cmd;
    logic single_mode, level_trig, vec_mode, auto_eoi, buffered, special_nest;
    logic eoi_pulse, poll_pulse, isr_clr, init_busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pic_cmd_if u_pic_cmd_if (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string req);
        addr = a; rd_en = 1'b1;
        #1;
        chk(req, rdata, exp);
        rd_en = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 busy", {7'd0, init_busy}, 8'h00);
        chk("R1 imr", imr, 8'h00);
        chk("R1 vec", {3'd0, vec_base}, 8'h00);
        chk("R1 pulses", {5'd0, eoi_pulse, poll_pulse, isr_clr}, 8'h00);
        rd(1'b0, IRRV, "R1 read-select");

        // table walk
        for (int i = 0; i <= 14; i++) begin
            wr(TBL[i].wa, TBL[i].wd);
            rd(TBL[i].ra, TBL[i].exp, $sformatf("R%0d row %0d", TBL[i].req, i));
        end
        // R11: short sequence ended on mask-free path; R5 skip confirmed above
        chk("R11 busy after table", {7'd0, init_busy}, 8'h00);
        chk("R3 vec after table", {3'd0, vec_base}, 8'h0F);
        chk("R2 single/level", {6'd0, single_mode, level_trig}, 8'h03);
        chk("R4 casc single", casc_cfg, 8'h00);

        // R2 pulse timing and full cascaded slave sequence with mode word
        wr(1'b0, 8'h11);
        chk("R2 isr_clr high", {7'd0, isr_clr}, 8'h01);
        chk("R2 busy", {7'd0, init_busy}, 8'h01);
        @(negedge clk);
        chk("R2 isr_clr drop", {7'd0, isr_clr}, 8'h00);
        wr(1'b1, 8'h80);
        chk("R3 vec", {3'd0, vec_base}, 8'h10);
        wr(1'b1, 8'h02);
        chk("R4 casc", casc_cfg, 8'h02);
        chk("R11 busy before mode", {7'd0, init_busy}, 8'h01);
        wr(1'b1, 8'h1F);
        chk("R5 modes", {4'd0, vec_mode, auto_eoi, buffered, special_nest}, 8'h0F);
        chk("R11 busy end", {7'd0, init_busy}, 8'h00);

        // R9: end of interrupt
        wr(1'b0, 8'h60);
        chk("R9 eoi pulse", {5'd0, eoi_pulse, 2'd0}, 8'h04);
        chk("R9 eoi cmd", {5'd0, eoi_cmd}, 8'h03);
        @(negedge clk);
        chk("R9 eoi drop", {7'd0, eoi_pulse}, 8'h00);

        // R8: poll, read selection unchanged
        wr(1'b0, 8'h0C);
        chk("R8 poll pulse", {7'd0, poll_pulse}, 8'h01);
        @(negedge clk);
        chk("R8 poll drop", {7'd0, poll_pulse}, 8'h00);
        rd(1'b0, IRRV, "R7 unchanged by poll");

        // R10: address-0 commands ignored during init
        wr(1'b0, 8'h11);
        wr(1'b0, 8'h20);
        chk("R10 no eoi in init", {7'd0, eoi_pulse}, 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, IRRV, "R10 rsel ignored in init");
        chk("R10 still busy", {7'd0, init_busy}, 8'h01);
        // R2: restart in cascade step, then single path
        wr(1'b1, 8'h08);
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h10);
        chk("R3 vec restart", {3'd0, vec_base}, 8'h02);
        chk("R2 restart busy", {7'd0, init_busy}, 8'h01);
        wr(1'b1, 8'h01);
        chk("R11 done", {7'd0, init_busy}, 8'h00);
        chk("R4 casc zero", casc_cfg, 8'h00);
        chk("R5 vec_mode", {7'd0, vec_mode}, 8'h01);

        @(negedge clk);
        rd_en = 1'b0; addr = 1'b1;
        #1 chk("R10 rdata idle", rdata, 8'h00);

        finish_run();
    end

endmodule